// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire serial bus that a target device has left stuck. The usual cause is a transfer cut short, for example by a reset while the target was sending a byte. The target keeps holding the data line low until it sees enough clock edges to finish that byte. The block drives the clock and data wires through drive-low enables, in the open-drain style. It works in four steps:

1. It releases both wires.
2. It waits, with a bound, for any clock stretching to end.
3. It forces clock pulses until the data line reads high.
4. It closes with a START condition and then a STOP condition, so that every target returns to idle.

A controller starts the block with a single-cycle request, then watches `busy_o`, `done_o` and `err_o`. The raw wire levels enter through a two-flop synchronizer. All timing is set by parameters counted in system clock cycles:

- the poll interval for the clock line;
- the total window allowed for clock stretching;
- the half-period used for the forced pulses and for the START/STOP spacing.

The default half-period gives a 100 kHz pace. The default poll interval and window give 500 µs and 40 ms at 100 MHz. `HALF_CYC` must be at least 3 so that a released line can pass the synchronizer before the next check.

Top module: `i2c_unjam`

## Requirements
- R1: Out of reset, `busy_o`, `done_o`, `err_o`, `scl_oe_o` and `sda_oe_o` are all low.
- R2: A `start_i` pulse while idle is accepted on that clock edge. `busy_o` is high from the next cycle. While waiting for the clock line, neither enable is asserted.
- R3: While waiting, the synchronized clock line is sampled once every `POLL_CYC` cycles. The first sample is taken `POLL_CYC` cycles after acceptance. The first high sample ends the wait, so a stretch of any length shorter than the window is tolerated.
- R4: If all `ceil(TIMEOUT_CYC/POLL_CYC)` samples read low, the block ends with `err_o` and no pulses. `busy_o` is then high for exactly that number of samples times `POLL_CYC` cycles.
- R5: Before each forced pulse the data line is sampled for one cycle, and pulsing stops once it reads high. Each pulse holds `scl_oe_o` high for `HALF_CYC` cycles, then releases the clock for `HALF_CYC` cycles.
- R6: At most 9 pulses are issued, covering 8 data bits and the acknowledge slot. If the data line is still low at the check after the ninth pulse, the block ends with `err_o` and issues no START/STOP.
- R7: On success, `sda_oe_o` is high for exactly `HALF_CYC` cycles while `scl_oe_o` is low (START). Both are then low for `HALF_CYC` cycles (STOP) before `done_o`. A successful run with k pulses keeps `busy_o` high for `POLL_CYC·p + (k+1) + 2·HALF_CYC·k + 2·HALF_CYC` cycles, where p is the number of clock-line samples taken.
- R8: `done_o` and `err_o` are single-cycle pulses and are never high together. Each appears in the first cycle in which `busy_o` is low again.
- R9: A `start_i` pulse while busy is ignored. It does not restart, extend or repeat the sequence.
- R10: When the sequence ends, with success or error, both enables are low and stay low until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to run the recovery sequence |
| scl_i | input | 1 | Raw level of the clock wire |
| sda_i | input | 1 | Raw level of the data wire |
| busy_o | output | 1 | High from the accepted request until the block returns to idle |
| done_o | output | 1 | One-cycle pulse: bus recovered |
| err_o | output | 1 | One-cycle pulse: clock never freed, or data still held after 9 pulses |
| scl_oe_o | output | 1 | Drive-low enable for the clock wire |
| sda_oe_o | output | 1 | Drive-low enable for the data wire |

## Verification
The bench builds the block with `POLL_CYC=8`, `TIMEOUT_CYC=64` and `HALF_CYC=4`. That gives an eight-sample stretch window, so the full timeout path takes tens of cycles rather than millions. The run covers:

- the exact busy length on timeout;
- a stretch that ends part-way through the window;
- targets that let go of the data line after 0, 3 and 9 pulses;
- a target that never lets go.

With these values, the nine-pulse limit and the START/STOP spacing can be measured cycle by cycle against the formula in R7.

// File: rtl/i2c_unjam_pkg.sv
`timescale 1ns/1ps
package i2c_unjam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SCL,
    ST_CHK_SDA,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_GEN_START,
    ST_GEN_STOP
  } unjam_state_e;

  // number of clock-line samples that fit in the stretch window (rounded up)
  function automatic int poll_count(input int timeout_cyc, input int poll_cyc);
    return (timeout_cyc + poll_cyc - 1) / poll_cyc;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // width of a countdown that must hold the larger of the two reload values
  function automatic int timer_width(input int poll_cyc, input int half_cyc);
    return $clog2(max_of(poll_cyc, half_cyc) + 1);
  endfunction

  // width of a counter that must reach n - 1 (never below 1 bit)
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/unjam_sync.sv
`timescale 1ns/1ps
module unjam_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);

  // idle bus reads high, so the flops reset to 1
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/unjam_timer.sv
`timescale 1ns/1ps
module unjam_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/unjam_ctrl.sv
`timescale 1ns/1ps
module unjam_ctrl
  import i2c_unjam_pkg::*;
#(
  parameter int POLL_CYC    = 50000,
  parameter int TIMEOUT_CYC = 4000000,
  parameter int HALF_CYC    = 500,
  parameter int MAX_PULSES  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic tmr_expired_i,
  output logic tmr_load_o,
  output logic [timer_width(POLL_CYC, HALF_CYC)-1:0] tmr_val_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic scl_oe_o,
  output logic sda_oe_o
);

  localparam int TW     = timer_width(POLL_CYC, HALF_CYC);
  localparam int NPOLL  = poll_count(TIMEOUT_CYC, POLL_CYC);
  localparam int PW     = cnt_width(NPOLL);
  localparam int KW     = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0] POLL_RELOAD = TW'(POLL_CYC - 1);
  localparam logic [TW-1:0] HALF_RELOAD = TW'(HALF_CYC - 1);

  unjam_state_e state_q, state_n;
  logic [PW-1:0] poll_q;
  logic [KW-1:0] pls_q;
  logic          done_q, err_q;

  // named internal events
  logic poll_last, pls_max;
  logic poll_inc, poll_clr, pls_inc, pls_clr;
  logic fin_ok, fin_err;

  assign poll_last = (poll_q == PW'(NPOLL - 1));
  assign pls_max   = (pls_q == KW'(MAX_PULSES));

  always_comb begin
    state_n    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    poll_inc   = 1'b0;
    poll_clr   = 1'b0;
    pls_inc    = 1'b0;
    pls_clr    = 1'b0;
    fin_ok     = 1'b0;
    fin_err    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_n    = ST_WAIT_SCL;
          tmr_load_o = 1'b1;
          tmr_val_o  = POLL_RELOAD;
          poll_clr   = 1'b1;
          pls_clr    = 1'b1;
        end
      end
      ST_WAIT_SCL: begin
        if (tmr_expired_i) begin
          if (scl_s_i) begin
            state_n = ST_CHK_SDA;
          end else if (poll_last) begin
            state_n = ST_IDLE;
            fin_err = 1'b1;
          end else begin
            tmr_load_o = 1'b1;
            tmr_val_o  = POLL_RELOAD;
            poll_inc   = 1'b1;
          end
        end
      end
      ST_CHK_SDA: begin
        if (sda_s_i) begin
          state_n    = ST_GEN_START;
          tmr_load_o = 1'b1;
          tmr_val_o  = HALF_RELOAD;
        end else if (pls_max) begin
          state_n = ST_IDLE;
          fin_err = 1'b1;
        end else begin
          state_n    = ST_PULSE_LO;
          tmr_load_o = 1'b1;
          tmr_val_o  = HALF_RELOAD;
        end
      end
      ST_PULSE_LO: begin
        if (tmr_expired_i) begin
          state_n    = ST_PULSE_HI;
          tmr_load_o = 1'b1;
          tmr_val_o  = HALF_RELOAD;
        end
      end
      ST_PULSE_HI: begin
        if (tmr_expired_i) begin
          state_n = ST_CHK_SDA;
          pls_inc = 1'b1;
        end
      end
      ST_GEN_START: begin
        if (tmr_expired_i) begin
          state_n    = ST_GEN_STOP;
          tmr_load_o = 1'b1;
          tmr_val_o  = HALF_RELOAD;
        end
      end
      ST_GEN_STOP: begin
        if (tmr_expired_i) begin
          state_n = ST_IDLE;
          fin_ok  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      poll_q  <= '0;
      pls_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= fin_ok;
      err_q   <= fin_err;
      if (poll_clr)      poll_q <= '0;
      else if (poll_inc) poll_q <= poll_q + 1'b1;
      if (pls_clr)       pls_q  <= '0;
      else if (pls_inc)  pls_q  <= pls_q + 1'b1;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign scl_oe_o = (state_q == ST_PULSE_LO);
  assign sda_oe_o = (state_q == ST_GEN_START);

  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !err_o);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |=> !(done_o || err_o));
  // R8
  end_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> (!busy_o && $past(busy_o)));
  // R6
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pls_q <= KW'(MAX_PULSES));
  // R7
  sda_only_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> !scl_oe_o);
  // R5
  pulse_after_low_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe_o) |-> !$past(sda_s_i));
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !fin_ok && !fin_err) |=> busy_o);
  // R10
  released_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> (!scl_oe_o && !sda_oe_o));

endmodule

// File: rtl/i2c_unjam.sv
`timescale 1ns/1ps
module i2c_unjam
  import i2c_unjam_pkg::*;
#(
  parameter int POLL_CYC    = 50000,
  parameter int TIMEOUT_CYC = 4000000,
  parameter int HALF_CYC    = 500,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic scl_oe_o,
  output logic sda_oe_o
);

  localparam int TW = timer_width(POLL_CYC, HALF_CYC);

  logic [1:0]    line_sync;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;

  unjam_sync #(.LINES(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sda_i, scl_i}),
    .sync_o (line_sync)
  );

  unjam_timer #(.W(TW)) i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  unjam_ctrl #(
    .POLL_CYC    (POLL_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .HALF_CYC    (HALF_CYC),
    .MAX_PULSES  (MAX_PULSES)
  ) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .scl_s_i       (line_sync[0]),
    .sda_s_i       (line_sync[1]),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .scl_oe_o      (scl_oe_o),
    .sda_oe_o      (sda_oe_o)
  );

endmodule

// File: tb/test_i2c_unjam.sv
`timescale 1ns/1ps
module test_i2c_unjam;

  localparam int POLL    = 8;
  localparam int TIMEOUT = 64;
  localparam int HALF    = 4;
  localparam int NPOLL   = (TIMEOUT + POLL - 1) / POLL;

  typedef struct {
    bit    is_err;
    int    pulses;
    int    sda_w;
    int    busy_len;   // -1: not checked
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, err_o, scl_oe_o, sda_oe_o;

  // target / bus model
  logic stretch = 1'b0;
  logic hold_forever = 1'b0;
  int   hold_k = 0;
  logic tgt_clear = 1'b0;
  int   rel_cnt = 0;
  logic scl_oe_d = 1'b0;
  logic scl_i, sda_i;

  assign scl_i = !scl_oe_o && !stretch;
  assign sda_i = !sda_oe_o && !(hold_forever || (rel_cnt < hold_k));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    scl_oe_d <= scl_oe_o;
    if (tgt_clear)                   rel_cnt <= 0;
    else if (scl_oe_d && !scl_oe_o)  rel_cnt <= rel_cnt + 1;
  end

  i2c_unjam #(.POLL_CYC(POLL), .TIMEOUT_CYC(TIMEOUT), .HALF_CYC(HALF)) i_i2c_unjam (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_i(scl_i), .sda_i(sda_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  exp_t exp_q[$];
  int n_chk_a = 0, n_fail_a = 0;
  int n_chk_m = 0, n_fail_m = 0;

  // restated busy length for a run that saw the clock high at sample p
  function automatic int busy_len(input int p, input int k, input bit is_err);
    return POLL * p + (k + 1) + 2 * HALF * k + (is_err ? 0 : 2 * HALF);
  endfunction

  // ---------------- monitor / scoreboard ----------------
  int m_busy = 0, m_pulses = 0, m_sdaw = 0;
  logic m_pscl = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_pulses = 0; m_sdaw = 0; m_pscl = 1'b0;
    end else begin
      if (busy_o)                m_busy++;
      if (scl_oe_o && !m_pscl)   m_pulses++;
      if (sda_oe_o)              m_sdaw++;
      m_pscl = scl_oe_o;
      if (done_o || err_o) begin
        if (exp_q.size() == 0) begin
          n_chk_m++; n_fail_m++;
          $display("FAIL R9 unexpected outcome: actual done=%0d err=%0d expected none", done_o, err_o);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          n_chk_m++;
          if (done_o && err_o) begin
            n_fail_m++;
            $display("FAIL R8 %s: done and err both high, expected one", e.tag);
          end
          n_chk_m++;
          if (err_o != e.is_err) begin
            n_fail_m++;
            $display("FAIL %s err: actual %0d expected %0d", e.tag, err_o, e.is_err);
          end
          n_chk_m++;
          if (m_pulses != e.pulses) begin
            n_fail_m++;
            $display("FAIL R5 %s pulses: actual %0d expected %0d", e.tag, m_pulses, e.pulses);
          end
          n_chk_m++;
          if (m_sdaw != e.sda_w) begin
            n_fail_m++;
            $display("FAIL R7 %s start width: actual %0d expected %0d", e.tag, m_sdaw, e.sda_w);
          end
          if (e.busy_len >= 0) begin
            n_chk_m++;
            if (m_busy != e.busy_len) begin
              n_fail_m++;
              $display("FAIL %s busy length: actual %0d expected %0d", e.tag, m_busy, e.busy_len);
            end
          end
          n_chk_m++;
          if (scl_oe_o || sda_oe_o || busy_o) begin
            n_fail_m++;
            $display("FAIL R10 %s lines at end: actual scl_oe=%0d sda_oe=%0d busy=%0d expected 0 0 0",
                     e.tag, scl_oe_o, sda_oe_o, busy_o);
          end
        end
        m_busy = 0; m_pulses = 0; m_sdaw = 0;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic chk(input bit ok, input string msg, input int act, input int exp_v);
    n_chk_a++;
    if (!ok) begin
      n_fail_a++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp_v);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic set_target(input int k, input bit forever_hold);
    @(negedge clk);
    hold_k = k; hold_forever = forever_hold; tgt_clear = 1'b1;
    @(negedge clk) tgt_clear = 1'b0;
  endtask

  task automatic push(input bit is_err, input int k, input int blen, input string tag);
    exp_t e;
    e.is_err = is_err; e.pulses = k; e.sda_w = is_err ? 0 : HALF;
    e.busy_len = blen; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic settle();
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o,   "R1 busy after reset",   busy_o, 0);
    chk(!done_o && !err_o, "R1 done/err after reset", done_o | err_o, 0);
    chk(!scl_oe_o, "R1 scl_oe after reset", scl_oe_o, 0);
    chk(!sda_oe_o, "R1 sda_oe after reset", sda_oe_o, 0);

    // bus already free: no pulses, START/STOP, done
    set_target(0, 1'b0);
    push(1'b0, 0, busy_len(1, 0, 1'b0), "R7 free bus");
    pulse_start();
    chk(busy_o, "R2 busy after accepted start", busy_o, 1);
    chk(!scl_oe_o && !sda_oe_o, "R2 lines released while waiting", scl_oe_o | sda_oe_o, 0);
    settle();

    // target releases after 3 pulses; extra start while busy is ignored
    set_target(3, 1'b0);
    push(1'b0, 3, busy_len(1, 3, 1'b0), "R5 k=3");
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();   // R9 ignored
    settle();
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (busy_o) quiet = 1'b0;
      end
      chk(quiet, "R9 no rerun after start while busy", !quiet, 0);
    end

    // target releases after exactly 9 pulses: still success
    set_target(9, 1'b0);
    push(1'b0, 9, busy_len(1, 9, 1'b0), "R6 k=9");
    pulse_start();
    settle();

    // target never releases: error after 9 pulses, no START/STOP
    set_target(0, 1'b1);
    push(1'b1, 9, busy_len(1, 9, 1'b1), "R6 stuck data");
    pulse_start();
    settle();
    set_target(0, 1'b0);

    // clock stretched for part of the window
    stretch = 1'b1;
    push(1'b0, 0, -1, "R3 stretch");
    pulse_start();
    repeat (20) @(negedge clk);
    stretch = 1'b0;
    settle();

    // clock stuck low for the whole window
    stretch = 1'b1;
    push(1'b1, 0, POLL * NPOLL, "R4 scl timeout");
    pulse_start();
    settle();
    stretch = 1'b0;

    // recovers normally afterwards
    set_target(2, 1'b0);
    push(1'b0, 2, busy_len(1, 2, 1'b0), "R5 k=2");
    pulse_start();
    settle();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_chk_a++; n_fail_a++;
        $display("FAIL watchdog: actual expired expected finished");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk_a + n_chk_m, n_fail_a + n_fail_m);
    $finish;
  end

endmodule